// File: doc/BRIEF.md
# Paged Serial EEPROM Slave on a Two-Wire Bus

This block is a synchronous slave on a two-wire serial bus, in the I2C style. It sits in front of a byte-wide storage array that is split into 16-byte pages. The array holds 2, 4, 8 or 16 kilobits, and a parameter picks the size.

SCL and SDA are oversampled with the system clock. The block finds START and STOP conditions on the bus. It checks the device byte and acknowledges each byte it accepts.

A write works in two steps. First it gives a word address. Then it loads bytes into a page buffer. When the STOP arrives, the buffer is committed in a single timed internal write cycle. A read streams bytes out from the current address and steps the address after each byte.

The device byte carries three extension bits. How they are used depends on the size. Some of them are compared against the device-select pins, and the rest become the high-order bits of the array address. A write-protect input blocks every commit.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, so the line is released.
- R2: With no START, nothing on the bus has any effect. A byte clocked in with no START gets no acknowledge.
- R3: The first byte after a START is the device byte: bits [7:4] are the code 1010, bits [3:1] are the extension bits, and bit 0 is the direction (1 = read, 0 = write). If the code or the pin match fails, the block does not acknowledge. It then ignores the bus until the next START.
- R4: The number of internal address bits is log2(SIZE_KB)-1. These bits are taken from the low end of device-byte bits [3:1], and they supply the high-order array address bits. The remaining upper extension bits must equal the matching `dev_pins` bits. For example, at 4 Kb, bits [3:2] must match pins [2:1], and bit 1 supplies address bit 8.
- R5: In write mode, the block pulls SDA low during the 9th clock of the word-address byte and of every data byte.
- R6: The data bytes of a write go into a page buffer. The array does not change until the STOP. After the internal write cycle, the buffered bytes are all in the array.
- R7: If a write carries more than 16 data bytes, the low four address bits wrap inside the page. The later bytes overwrite the earlier ones.
- R8: From the STOP that starts a commit, and for WR_CYCLES clocks after it, the device byte gets no acknowledge.
- R9: When `wp` is high at the STOP, no internal write cycle runs and the array stays unchanged.
- R10: A read sends the byte at the current address, MSB first. After each byte the address goes up by one. From the last array location it rolls over to 0.
- R11: When the master gives a NoACK after a read byte, the block stops transmitting. It keeps SDA released until the next START.
- R12: `sda_oe` changes only while SCL is low.
- R13: A START that arrives in the middle of a byte drops that byte. It also restarts reception of the device byte, and no partial data is buffered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_pins | input | 3 | Device-select pins |
| wp | input | 1 | Write protect, active high |

## Verification
Two events can land in the same window. One is the internal write cycle coming to an end. The other is the decision on a new device byte. The bench provokes this with back-to-back acknowledge polling straight after each committing STOP.

It expects at least one refused device byte and then an accepted one. A read of the committed page must then return the scoreboard contents. This shows that the NACK window and the commit are tied to the same timer expiry.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_RDAT
  } eep_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, sda_m, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_p <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_p <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int AW  = 8,
  parameter int PB  = 16,
  localparam int PIW = $clog2(PB),
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             buf_we,
  input  logic [PIW-1:0]   buf_idx,
  input  logic [7:0]       buf_data,
  input  logic             buf_clr,
  input  logic             commit,
  input  logic [AW-PIW-1:0] commit_page,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic             has_data
);
  logic [7:0]    mem_q [DEPTH];
  logic [7:0]    buf_q [PB];
  logic [PB-1:0] vld_q, vld_d;

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PB; i++) begin
        if (vld_q[i]) mem_q[{commit_page, PIW'(i)}] <= buf_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) buf_q[buf_idx] <= buf_data;
  end

  always_comb begin
    vld_d = vld_q;
    if (buf_clr || commit) vld_d = '0;
    else if (buf_we) vld_d[buf_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_data  = mem_q[rd_addr];
  assign has_data = |vld_q;

  AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> has_data); // R6
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave #(
  parameter int SIZE_KB    = 2,
  parameter int WR_CYCLES  = 5000,
  parameter int PAGE_BYTES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] dev_pins,
  input  logic       wp
);
  import eep_pkg::*;

  localparam int HI_BITS = $clog2(SIZE_KB) - 1;
  localparam int AW      = 8 + HI_BITS;
  localparam int PIW     = $clog2(PAGE_BYTES);
  localparam int CW      = $clog2(WR_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_state_e    state_q, state_d;
  logic [3:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          oe_q, oe_d;
  logic          busy_q, busy_d;
  logic [CW-1:0] tmr_q, tmr_d;
  logic          buf_we, buf_clr, commit, has_data;
  logic [7:0]    rd_data;
  logic          ext_ok;
  logic [AW-1:0] dev_addr, wadr_addr;

  eep_bus_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_store #(.AW(AW), .PB(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .buf_we(buf_we), .buf_idx(addr_q[PIW-1:0]), .buf_data(sh_q),
    .buf_clr(buf_clr), .commit(commit), .commit_page(addr_q[AW-1:PIW]),
    .rd_addr(addr_q), .rd_data(rd_data), .has_data(has_data)
  );

  // split of the extension bits between pin match and internal address
  generate
    if (HI_BITS == 0) begin : g_pins3
      assign ext_ok    = (sh_q[3:1] == dev_pins);
      assign dev_addr  = addr_q;
      assign wadr_addr = sh_q;
    end else if (HI_BITS == 3) begin : g_pins0
      assign ext_ok    = 1'b1;
      assign dev_addr  = {sh_q[3:1], addr_q[7:0]};
      assign wadr_addr = {addr_q[AW-1:8], sh_q};
    end else begin : g_pins_mix
      assign ext_ok    = (sh_q[3:HI_BITS+1] == dev_pins[2:HI_BITS]);
      assign dev_addr  = {sh_q[HI_BITS:1], addr_q[7:0]};
      assign wadr_addr = {addr_q[AW-1:8], sh_q};
    end
  endgenerate

  always_comb begin
    state_d = state_q; bit_d = bit_q; sh_d = sh_q; addr_d = addr_q;
    oe_d = oe_q; busy_d = busy_q; tmr_d = tmr_q;
    buf_we = 1'b0; buf_clr = 1'b0; commit = 1'b0;

    if (busy_q) begin
      tmr_d = tmr_q - 1'b1;
      if (tmr_q == CW'(1)) begin
        commit = 1'b1;
        busy_d = 1'b0;
      end
    end

    if (start_det) begin
      state_d = ST_DEV; bit_d = '0; oe_d = 1'b0;
    end else if (stop_det) begin
      if (state_q == ST_WDAT && has_data && !wp) begin
        busy_d = 1'b1;
        tmr_d  = CW'(WR_CYCLES);
      end
      state_d = ST_IDLE; bit_d = '0; oe_d = 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (scl_rise) begin
            if (bit_q < 4'd8) begin
              sh_d  = {sh_q[6:0], sda_s};
              bit_d = bit_q + 4'd1;
            end else begin
              bit_d = 4'd9;
            end
          end else if (scl_fall && bit_q == 4'd8) begin
            if (state_q == ST_DEV) begin
              if (sh_q[7:4] == DEV_CODE && ext_ok && !busy_q) begin
                oe_d = 1'b1;
                if (!sh_q[0]) begin
                  addr_d  = dev_addr;
                  buf_clr = 1'b1;
                end
              end else begin
                state_d = ST_IDLE; bit_d = '0;
              end
            end else if (state_q == ST_WADR) begin
              oe_d   = 1'b1;
              addr_d = wadr_addr;
            end else begin
              oe_d   = 1'b1;
              buf_we = 1'b1;
              addr_d[PIW-1:0] = addr_q[PIW-1:0] + PIW'(1);
            end
          end else if (scl_fall && bit_q == 4'd9) begin
            oe_d = 1'b0; bit_d = '0;
            if (state_q == ST_DEV && sh_q[0]) begin
              state_d = ST_RDAT;
              sh_d    = rd_data;
              oe_d    = ~rd_data[7];
            end else if (state_q == ST_DEV) begin
              state_d = ST_WADR;
            end else if (state_q == ST_WADR) begin
              state_d = ST_WDAT;
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            if (bit_q < 4'd8) begin
              bit_d = bit_q + 4'd1;
            end else begin
              bit_d  = 4'd9;
              addr_d = addr_q + 1'b1;
              if (sda_s) begin
                state_d = ST_IDLE; bit_d = '0;
              end
            end
          end else if (scl_fall) begin
            if (bit_q >= 4'd1 && bit_q < 4'd8) begin
              sh_d = {sh_q[6:0], 1'b0};
              oe_d = ~sh_q[6];
            end else if (bit_q == 4'd8) begin
              oe_d = 1'b0;
            end else if (bit_q == 4'd9) begin
              bit_d = '0;
              sh_d  = rd_data;
              oe_d  = ~rd_data[7];
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; bit_q <= '0; sh_q <= '0; addr_q <= '0;
      oe_q <= 1'b0; busy_q <= 1'b0; tmr_q <= '0;
    end else begin
      state_q <= state_d; bit_q <= bit_d; sh_q <= sh_d; addr_q <= addr_d;
      oe_q <= oe_d; busy_q <= busy_d; tmr_q <= tmr_d;
    end
  end

  assign sda_oe = oe_q;

  AST_OE_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(oe_q)); // R12
  AST_BUSY_BLOCKS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (state_q == ST_IDLE || state_q == ST_DEV)); // R8
  AST_WP_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !$past(wp)); // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !oe_q); // R11
endmodule

// File: tb/eep_i2c_slave_tb.sv
module eep_i2c_slave_tb;
  localparam int SIZE_KB = 4;
  localparam int WRC     = 400;
  localparam int DEPTH   = SIZE_KB * 128;
  localparam time Q      = 100ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [2:0] pins = 3'b101;

  always #10ns clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  eep_i2c_slave #(.SIZE_KB(SIZE_KB), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .dev_pins(pins), .wp(wp)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];
  logic [7:0] wdat [32];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(g == e, t, g, e);
    end
  end

  function automatic logic [7:0] devb(input bit a8, input bit rd);
    return {4'b1010, 1'b1, 1'b0, a8, rd};
  endfunction

  task automatic start_c();
    sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic stop_c();
    sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask

  task automatic bit_c(input bit b, output bit r);
    bit r2;
    sda_m = b; #Q; scl = 1'b1; #Q; r = sda_line; #Q; r2 = sda_line;
    chk(r == r2, "R12", r2, r);
    scl = 1'b0; #Q;
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) bit_c(b[i], r);
    bit_c(1'b1, r);
    ack = ~r;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] d);
    bit r;
    for (int i = 7; i >= 0; i--) begin bit_c(1'b1, r); d[i] = r; end
    bit_c(~mack, r);
  endtask

  task automatic poll(output int nacks);
    bit ack;
    nacks = 0;
    for (int k = 0; k < 20; k++) begin
      start_c(); wbyte(devb(1'b0, 1'b0), ack); stop_c();
      if (ack) break;
      nacks++;
    end
  endtask

  task automatic do_write(input logic [8:0] a, input int n);
    bit ack;
    int nk;
    start_c();
    wbyte(devb(a[8], 1'b0), ack); chk(ack, "R3", ack, 1);
    wbyte(a[7:0], ack);           chk(ack, "R5", ack, 1);
    for (int i = 0; i < n; i++) begin
      wbyte(wdat[i], ack); chk(ack, "R5", ack, 1);
      if (!wp) model[{a[8:4], 4'(a[3:0] + i)}] = wdat[i];
    end
    stop_c();
    poll(nk);
    if (wp) chk(nk == 0, "R9", nk, 0);
    else    chk(nk >= 1, "R8", nk, 1);
  endtask

  task automatic do_read(input logic [8:0] a, input int n, input string tag);
    bit ack;
    logic [7:0] d;
    start_c();
    wbyte(devb(a[8], 1'b0), ack); chk(ack, tag, ack, 1);
    wbyte(a[7:0], ack);           chk(ack, tag, ack, 1);
    start_c();
    wbyte(devb(1'b0, 1'b1), ack); chk(ack, tag, ack, 1);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model[9'(a + i)]); tag_q.push_back(tag);
      rbyte(i < n - 1, d);
      got_q.push_back(d);
    end
    stop_c();
    #Q;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack, r;
    logic [7:0] d;
    bit seen_oe;
    repeat (5) @(posedge clk);
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    @(negedge clk); rst_n = 1'b1; #3ns;
    repeat (3) @(negedge clk);
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);

    // byte with no START
    scl = 1'b0; #Q;
    wbyte(devb(1'b0, 1'b0), ack); chk(!ack, "R2", ack, 0);
    stop_c();

    // pin mismatch, then ignored until START
    start_c();
    wbyte(8'b1010_0000, ack); chk(!ack, "R3", ack, 0);
    wbyte(devb(1'b0, 1'b0), ack); chk(!ack, "R3", ack, 0);
    stop_c();
    start_c();
    wbyte(8'b1011_1000, ack); chk(!ack, "R3", ack, 0);
    stop_c();

    // two pages differing only in address bit 8
    for (int i = 0; i < 4; i++) wdat[i] = 8'h10 + 8'(i);
    do_write(9'h0F0, 4);
    for (int i = 0; i < 4; i++) wdat[i] = 8'hC0 + 8'(i);
    do_write(9'h1F0, 4);
    do_read(9'h0F0, 4, "R4");
    do_read(9'h1F0, 4, "R6");

    // 20 bytes wrap inside the page
    for (int i = 0; i < 20; i++) wdat[i] = 8'h40 + 8'(i);
    do_write(9'h020, 20);
    do_read(9'h020, 16, "R7");

    // write protect
    wp = 1'b1;
    wdat[0] = 8'hEE; wdat[1] = 8'hDD;
    do_write(9'h020, 2);
    wp = 1'b0;
    do_read(9'h020, 2, "R9");

    // sequential read rollover from last location
    for (int i = 0; i < 16; i++) wdat[i] = 8'hA0 + 8'(i);
    do_write(9'h1F0, 16);
    for (int i = 0; i < 4; i++) wdat[i] = 8'h70 + 8'(i);
    do_write(9'h000, 4);
    do_read(9'h1FE, 4, "R10");

    // after NoACK the line stays released
    start_c();
    wbyte(devb(1'b0, 1'b1), ack); chk(ack, "R11", ack, 1);
    rbyte(1'b0, d);
    seen_oe = 1'b0;
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b1; #Q; scl = 1'b1; seen_oe |= sda_oe; #Q; seen_oe |= sda_oe;
      #Q; scl = 1'b0; #Q; seen_oe |= sda_oe;
    end
    chk(!seen_oe, "R11", seen_oe, 0);
    stop_c();

    // START in the middle of a data byte
    start_c();
    wbyte(devb(1'b1, 1'b0), ack); chk(ack, "R13", ack, 1);
    wbyte(8'hF0, ack);            chk(ack, "R13", ack, 1);
    bit_c(1'b0, r); bit_c(1'b1, r); bit_c(1'b0, r);
    start_c();
    wbyte(devb(1'b0, 1'b1), ack); chk(ack, "R13", ack, 1);
    exp_q.push_back(model[9'h1F0]); tag_q.push_back("R13");
    rbyte(1'b0, d); got_q.push_back(d);
    stop_c();
    #Q;
    do_read(9'h1F0, 2, "R13");

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule